// File: doc/BRIEF.md
# Indirect Interrupt Routing Register File

This block holds the programming state for a bank of interrupt input pins. Software reaches it through a 256-byte window that contains only two directly addressed registers. A 32-bit index register selects an internal register, and a 32-bit data window reads or writes the selected register. Behind the window sit a version word, a 4-bit identification field with a read-only alias, and one 64-bit routing entry per pin. Each routing entry is reached as two 32-bit halves.

The routing entries are presented in parallel to the pin-servicing logic. That logic returns per-pin pulses that set or clear each entry's remote-pending bit. Every accepted write to an entry produces a one-cycle "entry updated" strobe for that pin. When the pin's request input is high at the time of the write, a matching "service" strobe asks the servicing logic to re-evaluate the pin.

Top module: `irr_route_regs`

## Requirements
- R1: The index register sits at offset 0x00 and the data window at 0x10. The bus address is 8 bits wide, and the index register reads back the full 32 bits last written to it.
- R2: Index 0x00 reads as the version word: NPINS-1 in bits 23:16 and VERSION in bits 7:0 (0x00170011 with the defaults). Writes through the window to index 0x00 or index 0x02 change nothing.
- R3: A window write to index 0x01 loads bits 27:24 of the data into the ID. Indices 0x01 and 0x02 both read back the ID in bits 27:24 with all other bits zero.
- R4: For an index of 0x10 or above, the entry number is (index-0x10)>>1. An odd index reaches bits 63:32 of the entry and an even index reaches bits 31:0. Entry bit 14 is remote-pending and bit 16 is the mask.
- R5: A window access to an entry number at or above NPINS writes nothing and raises no strobe, and a read of it returns 0.
- R6: A low-half entry write stores bit 14 as 0, whatever the data holds in bit 14.
- R7: rem_set_i[i] sets entry i bit 14 and rem_clr_i[i] clears it. A set wins over a clear or over a low-half write in the same cycle.
- R8: The cycle after an accepted entry write, entry_upd_o carries a one-cycle pulse on the written pin only. service_o pulses in the same cycle when req_i for that pin was high during the write.
- R9: Reset loads every entry with 0x0000_0000_0001_0000 (mask set) and clears the index register and the ID.
- R10: Writes are accepted only when bus_size_i is 4 or 8 bytes. Writes of any other size change nothing and raise no strobe.
- R11: Reads of any offset other than 0x00 and 0x10 return 0, and so do window reads of indices 0x03 to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte offset within the region |
| bus_we_i | input | 1 | Write enable |
| bus_size_i | input | 4 | Access size in bytes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| req_i | input | NPINS | Current request bit per pin |
| rem_set_i | input | NPINS | Set remote-pending per pin |
| rem_clr_i | input | NPINS | Clear remote-pending per pin |
| entries_o | output | NPINS*64 | All routing entries, entry i at bits 64*i+63:64*i |
| entry_upd_o | output | NPINS | Entry-written strobe |
| service_o | output | NPINS | Re-evaluate strobe |

## Verification
Two functions can fall in the same cycle: a low-half bus write, which clears remote-pending, and a set pulse from the servicing logic on the same pin. The bench provokes this by holding rem_set_i high for the exact cycle of the window write. It then reads the entry back and expects bit 14 set next to the written data. A separate case raises the clear pulse alone, and a per-pin property checks that a set always lands.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int ENT_W    = 64;
  localparam int HALF_W   = 32;
  localparam int REM_BIT  = 14;
  localparam int MASK_BIT = 16;
  localparam int ID_LSB   = 24;
  localparam int ID_W     = 4;
  localparam logic [7:0]  OFS_SEL = 8'h00;
  localparam logic [7:0]  OFS_WIN = 8'h10;
  localparam logic [31:0] IX_VER  = 32'h0;
  localparam logic [31:0] IX_ID   = 32'h1;
  localparam logic [31:0] IX_ARB  = 32'h2;
  localparam logic [31:0] IX_TBL  = 32'h10;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;
endpackage

// File: rtl/irr_sel_decode.sv
module irr_sel_decode
  import irr_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic [31:0] sel_i,
  output logic        ver_o,
  output logic        id_o,
  output logic        arb_o,
  output logic        tbl_ok_o,
  output logic        hi_o,
  output logic [31:0] idx_o
);
  logic [31:0] off;

  assign off      = sel_i - IX_TBL;
  assign idx_o    = {1'b0, off[31:1]};
  assign hi_o     = off[0];
  assign ver_o    = (sel_i == IX_VER);
  assign id_o     = (sel_i == IX_ID);
  assign arb_o    = (sel_i == IX_ARB);
  assign tbl_ok_o = (sel_i >= IX_TBL) && (idx_o < 32'(NPINS));
endmodule

// File: rtl/irr_entry.sv
module irr_entry
  import irr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              rem_set_i,
  input  logic              rem_clr_i,
  output logic [ENT_W-1:0]  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= ENT_RST;
    end else begin
      if (wr_lo_i) q_o[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) q_o[ENT_W-1:HALF_W] <= wdata_i;
      // servicing-side set outranks any clear in the same cycle
      if (rem_set_i)                 q_o[REM_BIT] <= 1'b1;
      else if (wr_lo_i || rem_clr_i) q_o[REM_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/irr_route_regs.sv
module irr_route_regs
  import irr_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             bus_addr_i,
  input  logic                   bus_we_i,
  input  logic [3:0]             bus_size_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  input  logic [NPINS-1:0]       req_i,
  input  logic [NPINS-1:0]       rem_set_i,
  input  logic [NPINS-1:0]       rem_clr_i,
  output logic [NPINS*ENT_W-1:0] entries_o,
  output logic [NPINS-1:0]       entry_upd_o,
  output logic [NPINS-1:0]       service_o
);
  localparam logic [7:0] PIN_MAX = 8'(NPINS - 1);

  logic [31:0]     sel_q;
  logic [ID_W-1:0] id_q;
  logic            wr_ok, win_wr;
  logic            dec_ver, dec_id, dec_arb, dec_tbl, dec_hi;
  logic [31:0]     dec_idx;
  logic [NPINS-1:0] wr_lo_s, wr_hi_s;
  logic [ENT_W-1:0] ent_s [NPINS];

  assign wr_ok  = bus_we_i && (bus_size_i == 4'd4 || bus_size_i == 4'd8);
  assign win_wr = wr_ok && (bus_addr_i == OFS_WIN);

  irr_sel_decode #(.NPINS(NPINS)) u_dec (
    .sel_i    (sel_q),
    .ver_o    (dec_ver),
    .id_o     (dec_id),
    .arb_o    (dec_arb),
    .tbl_ok_o (dec_tbl),
    .hi_o     (dec_hi),
    .idx_o    (dec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_ok && bus_addr_i == OFS_SEL) sel_q <= bus_wdata_i;
      if (win_wr && dec_id) id_q <= bus_wdata_i[ID_LSB +: ID_W];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign wr_lo_s[i] = win_wr && dec_tbl && (dec_idx == 32'(i)) && !dec_hi;
    assign wr_hi_s[i] = win_wr && dec_tbl && (dec_idx == 32'(i)) &&  dec_hi;

    irr_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (wr_lo_s[i]),
      .wr_hi_i   (wr_hi_s[i]),
      .wdata_i   (bus_wdata_i),
      .rem_set_i (rem_set_i[i]),
      .rem_clr_i (rem_clr_i[i]),
      .q_o       (ent_s[i])
    );

    assign entries_o[i*ENT_W +: ENT_W] = ent_s[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_upd_o <= '0;
      service_o   <= '0;
    end else begin
      entry_upd_o <= wr_lo_s | wr_hi_s;
      service_o   <= (wr_lo_s | wr_hi_s) & req_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFS_SEL) begin
      bus_rdata_o = sel_q;
    end else if (bus_addr_i == OFS_WIN) begin
      if (dec_ver)              bus_rdata_o = {8'h00, PIN_MAX, 8'h00, VERSION};
      else if (dec_id || dec_arb) bus_rdata_o = {{(8-ID_W){1'b0}}, id_q, 24'h0};
      else if (dec_tbl) begin
        for (int i = 0; i < NPINS; i++)
          if (dec_idx == 32'(i))
            bus_rdata_o = dec_hi ? ent_s[i][ENT_W-1:HALF_W] : ent_s[i][HALF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irr_route_chk.sv
module irr_route_chk
  import irr_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [7:0]             bus_addr_i,
  input logic                   bus_we_i,
  input logic [3:0]             bus_size_i,
  input logic [31:0]            bus_rdata_o,
  input logic [NPINS-1:0]       req_i,
  input logic [NPINS-1:0]       rem_set_i,
  input logic [NPINS-1:0]       rem_clr_i,
  input logic [NPINS*ENT_W-1:0] entries_o,
  input logic [NPINS-1:0]       entry_upd_o,
  input logic [NPINS-1:0]       service_o,
  input logic [31:0]            sel_q,
  input logic [NPINS-1:0]       wr_lo_s
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  assert_upd_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(entry_upd_o));

  assert_svc_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (service_o & ~entry_upd_o) == '0);

  assert_svc_past_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (service_o != '0) |-> (service_o & ~$past(req_i)) == '0);

  assert_bad_size_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_size_i != 4'd4 && bus_size_i != 4'd8 &&
     rem_set_i == '0 && rem_clr_i == '0) |=> $stable(entries_o));

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != OFS_SEL && bus_addr_i != OFS_WIN) |-> bus_rdata_o == '0);

  assert_version_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFS_WIN && sel_q == IX_VER) |-> bus_rdata_o == VER_WORD);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assert_lo_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_lo_s[i] && !rem_set_i[i]) |=> !entries_o[i*ENT_W + REM_BIT]);

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rem_set_i[i] |=> entries_o[i*ENT_W + REM_BIT]);
  end
endmodule

bind irr_route_regs irr_route_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_size_i  (bus_size_i),
  .bus_rdata_o (bus_rdata_o),
  .req_i       (req_i),
  .rem_set_i   (rem_set_i),
  .rem_clr_i   (rem_clr_i),
  .entries_o   (entries_o),
  .entry_upd_o (entry_upd_o),
  .service_o   (service_o),
  .sel_q       (sel_q),
  .wr_lo_s     (wr_lo_s)
);

// File: tb/sim_irr_route_regs.sv
module sim_irr_route_regs;
  localparam int NPINS = 24;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  size;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 4'd4, 32'h0,        32'h0,        8'd9 },  // R9 index reset
    '{1'b1, 8'h00, 4'd4, 32'h0,        32'h0,        8'd2 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h00170011, 8'd2 },  // R2 version word
    '{1'b1, 8'h10, 4'd4, 32'hFFFFFFFF, 32'h0,        8'd2 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h00170011, 8'd2 },  // R2 write ignored
    '{1'b1, 8'h00, 4'd4, 32'h1,        32'h0,        8'd3 },
    '{1'b1, 8'h10, 4'd4, 32'hFA000000, 32'h0,        8'd3 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0A000000, 8'd3 },  // R3 id
    '{1'b1, 8'h00, 4'd4, 32'h2,        32'h0,        8'd3 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0A000000, 8'd3 },  // R3 alias
    '{1'b1, 8'h10, 4'd4, 32'h05000000, 32'h0,        8'd3 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0A000000, 8'd3 },  // R2 alias write ignored
    '{1'b1, 8'h00, 4'd4, 32'h10,       32'h0,        8'd9 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h00010000, 8'd9 },  // R9 entry mask
    '{1'b1, 8'h00, 4'd4, 32'h13,       32'h0,        8'd4 },
    '{1'b1, 8'h10, 4'd8, 32'hAB000000, 32'h0,        8'd4 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'hAB000000, 8'd4 },  // R4 high half
    '{1'b1, 8'h00, 4'd4, 32'h12,       32'h0,        8'd4 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h00010000, 8'd4 },  // R4 low half untouched
    '{1'b1, 8'h00, 4'd4, 32'h3E,       32'h0,        8'd4 },
    '{1'b1, 8'h10, 4'd4, 32'h0000A031, 32'h0,        8'd4 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0000A031, 8'd4 },  // R4 last entry
    '{1'b1, 8'h00, 4'd4, 32'h40,       32'h0,        8'd5 },
    '{1'b1, 8'h10, 4'd4, 32'h12345678, 32'h0,        8'd5 },
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0,        8'd5 },  // R5 out of range
    '{1'b1, 8'h00, 4'd4, 32'h05,       32'h0,        8'd11},
    '{1'b0, 8'h10, 4'd4, 32'h0,        32'h0,        8'd11},  // R11 gap index
    '{1'b0, 8'h00, 4'd4, 32'h0,        32'h05,       8'd1 },  // R1 readback
    '{1'b0, 8'h20, 4'd4, 32'h0,        32'h0,        8'd11},  // R11
    '{1'b0, 8'hF0, 4'd4, 32'h0,        32'h0,        8'd11},  // R11
    '{1'b1, 8'h00, 4'd2, 32'h10,       32'h0,        8'd10},
    '{1'b0, 8'h00, 4'd4, 32'h0,        32'h05,       8'd10},  // R10 size 2
    '{1'b1, 8'h00, 4'd1, 32'h77,       32'h0,        8'd10},
    '{1'b0, 8'h00, 4'd4, 32'h0,        32'h05,       8'd10},  // R10 size 1
    '{1'b1, 8'h20, 4'd4, 32'h99,       32'h0,        8'd1 },
    '{1'b0, 8'h00, 4'd4, 32'h0,        32'h05,       8'd1 }   // R1 other offset inert
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [7:0]        bus_addr_i = '0;
  logic              bus_we_i = 1'b0;
  logic [3:0]        bus_size_i = 4'd4;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic [NPINS-1:0]  req_i = '0, rem_set_i = '0, rem_clr_i = '0;
  logic [NPINS*64-1:0] entries_o;
  logic [NPINS-1:0]  entry_upd_o, service_o;
  logic [NPINS-1:0]  upd_cap, svc_cap;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irr_route_regs #(.NPINS(NPINS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_size_i(bus_size_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .req_i(req_i), .rem_set_i(rem_set_i), .rem_clr_i(rem_clr_i),
    .entries_o(entries_o), .entry_upd_o(entry_upd_o), .service_o(service_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz);
    bus_addr_i = a; bus_wdata_i = d; bus_size_i = sz; bus_we_i = 1'b1;
    @(negedge clk);
    upd_cap = entry_upd_o; svc_cap = service_o;
    bus_we_i = 1'b0; bus_size_i = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr_i = a; bus_we_i = 1'b0;
    #2;
    chk(bus_rdata_o === e, tag, 64'(bus_rdata_o), 64'(e));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(entries_o === {NPINS{64'h10000}}, "R9 entries after reset", entries_o[63:0], 64'h10000);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].addr, VEC[k].data, VEC[k].size);
      else rd(VEC[k].addr, VEC[k].exp, $sformatf("R%0d vector %0d", VEC[k].rq, k));
    end

    // R7 set pulse alone, then R6 low write clears it
    rem_set_i[2] = 1'b1; @(negedge clk); rem_set_i = '0;
    wr(8'h00, 32'h14, 4'd4);
    rd(8'h10, 32'h00014000, "R7 set");
    wr(8'h10, 32'h00004025, 4'd4);
    rd(8'h10, 32'h00000025, "R6 low write clears remote");

    // R7 set coincides with low write
    wr(8'h00, 32'h16, 4'd4);
    rem_set_i[3] = 1'b1;
    wr(8'h10, 32'h00000033, 4'd4);
    rem_set_i = '0;
    rd(8'h10, 32'h00004033, "R7 set beats low write");
    rem_clr_i[3] = 1'b1; @(negedge clk); rem_clr_i = '0;
    rd(8'h10, 32'h00000033, "R7 clear");

    // R8 strobes
    req_i = NPINS'(1) << 4;
    wr(8'h00, 32'h19, 4'd4);
    chk(upd_cap === '0, "R8 no strobe on index write", 64'(upd_cap), 64'd0);
    wr(8'h10, 32'h11000000, 4'd4);
    chk(upd_cap === NPINS'(1) << 4, "R8 upd pin4", 64'(upd_cap), 64'(NPINS'(1) << 4));
    chk(svc_cap === NPINS'(1) << 4, "R8 service pin4", 64'(svc_cap), 64'(NPINS'(1) << 4));
    @(negedge clk);
    chk(entry_upd_o === '0, "R8 single cycle", 64'(entry_upd_o), 64'd0);
    req_i = '0;
    wr(8'h00, 32'h1A, 4'd4);
    wr(8'h10, 32'h00000041, 4'd4);
    chk(upd_cap === NPINS'(1) << 5, "R8 upd pin5", 64'(upd_cap), 64'(NPINS'(1) << 5));
    chk(svc_cap === '0, "R8 no service without request", 64'(svc_cap), 64'd0);

    // R10 bad size on window
    wr(8'h10, 32'h00000099, 4'd2);
    chk(upd_cap === '0, "R10 no strobe", 64'(upd_cap), 64'd0);
    rd(8'h10, 32'h00000041, "R10 entry unchanged");

    // R5 out-of-range strobe
    wr(8'h00, 32'h40, 4'd4);
    wr(8'h10, 32'hFFFFFFFF, 4'd4);
    chk(upd_cap === '0, "R5 no strobe", 64'(upd_cap), 64'd0);

    // R9 reset mid-run
    rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    rd(8'h00, 32'h0, "R9 index cleared");
    wr(8'h00, 32'h1, 4'd4);
    rd(8'h10, 32'h0, "R9 id cleared");
    wr(8'h00, 32'h16, 4'd4);
    rd(8'h10, 32'h00010000, "R9 entry3 default");
    wr(8'h00, 32'h3E, 4'd4);
    rd(8'h10, 32'h00010000, "R9 entry23 default");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule